// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits beside the read path of a memory controller and keeps a record of the first ECC event it sees. The datapath raises a single-bit (corrected) strobe or a multi-bit (uncorrectable) strobe together with the failing address and the 8-bit syndrome. While no error is on record, a strobe freezes the upper address bits and the syndrome, and sets exactly one of two status flags. Until software clears that flag, every later strobe is dropped.

All of this is visible through one 32-bit register. The register also holds three control bits. One turns off scrub write-back after a corrected read. One routes a recorded multi-bit error to a system bus-error level. One routes a recorded single-bit error to an NMI level. Software releases the record by writing ones to the status flags, and capture is then armed for the next event.

Register layout: bit 31 scrub-disable (RW), bits 30:12 failing address bits 31:13 (RO), bits 11:4 syndrome (RO), bit 3 bus-error enable (RW), bit 2 NMI enable (RW), bit 1 multi-bit flag (RO, write 1 clears), bit 0 single-bit flag (RO, write 1 clears).

Top module: `ecc_err_capture`

## Requirements
- R1: During and after reset, the register reads 0, `nmi_o` and `bus_err_o` are 0, and `scrub_en_o` is 1.
- R2: With both flags clear, a single-bit strobe alone sets bit 0. It also loads `err_addr[31:13]` into bits 30:12 and the syndrome into bits 11:4. All of this is visible from the first clock edge after the strobe.
- R3: With both flags clear, a multi-bit strobe sets bit 1 and loads the address and syndrome fields in the same way.
- R4: If both strobes arrive in the same cycle while the flags are clear, only bit 1 is set. Bits 1 and 0 are never 1 together.
- R5: While bit 0 or bit 1 is set, strobes of either kind leave the flags, the address field and the syndrome field unchanged.
- R6: Writing 1 to bit 0 or bit 1 clears that flag. Writing 0 to it has no effect. Once the flags are clear, the next strobe is captured.
- R7: Every register write loads bits 31, 3 and 2 from the write data. Writes never change bits 30:4.
- R8: `scrub_en_o` is the inverse of bit 31.
- R9: `nmi_o` is 1 exactly when bit 0 and bit 2 are both 1.
- R10: `bus_err_o` is 1 exactly when bit 1 and bit 3 are both 1.
- R11: Whether a strobe is captured depends on the flags before the clock edge. A strobe that coincides with a write clearing a set flag is dropped. A strobe that coincides with any write while the flags are clear is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sbe_stb | input | 1 | Single-bit (corrected) error strobe |
| mbe_stb | input | 1 | Multi-bit (uncorrectable) error strobe |
| err_addr | input | ADDR_W | Failing address, valid with a strobe |
| err_syn | input | SYN_W | ECC syndrome, valid with a strobe |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read value |
| nmi_o | output | 1 | NMI level |
| bus_err_o | output | 1 | System bus-error level |
| scrub_en_o | output | 1 | Scrub write-back permitted |

## Verification
Directed scenarios drive each type of error strobe alone, both together, repeated strobes while a record is held, and strobes that coincide with writes. Together these separate correct first-event capture from priority mistakes and from records that get overwritten. Writes of all-zeros to the status bits, and writes of all-ones to the read-only fields, show which write paths may touch which bits. The enable bits are toggled with and without a recorded error, which separates the gating of the NMI and bus-error levels from the flags themselves.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int REG_W        = 32;
  localparam int BIT_SCRUB_DIS = 31;
  localparam int ADDR_HI      = 30;
  localparam int ADDR_LO      = 12;
  localparam int SYN_HI       = 11;
  localparam int SYN_LO       = 4;
  localparam int BIT_BERR_EN  = 3;
  localparam int BIT_NMI_EN   = 2;
  localparam int BIT_MBE      = 1;
  localparam int BIT_SBE      = 0;
  localparam int ADDR_KEEP    = ADDR_HI - ADDR_LO + 1;
  localparam int SYN_FIELD    = SYN_HI - SYN_LO + 1;

  typedef struct packed {
    logic scrub_dis;
    logic berr_en;
    logic nmi_en;
  } cap_ctrl_t;

  typedef struct packed {
    logic mbe;
    logic sbe;
  } cap_flags_t;
endpackage

// File: rtl/ecc_cap_rst_sync.sv
module ecc_cap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ecc_cap_ctrl.sv
module ecc_cap_ctrl
  import ecc_cap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  cap_ctrl_t wr_ctrl,
  output cap_ctrl_t ctrl
);
  cap_ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = wr_ctrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/ecc_cap_record.sv
module ecc_cap_record
  import ecc_cap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sbe_stb,
  input  logic                 mbe_stb,
  input  logic [ADDR_KEEP-1:0] addr_in,
  input  logic [SYN_FIELD-1:0] syn_in,
  input  cap_flags_t           clr,
  output cap_flags_t           flags,
  output logic [ADDR_KEEP-1:0] addr_q,
  output logic [SYN_FIELD-1:0] syn_q
);
  cap_flags_t flags_q, flags_d;
  logic       armed;
  logic       take;

  always_comb begin
    armed   = ~(flags_q.mbe | flags_q.sbe);
    take    = armed & (sbe_stb | mbe_stb);
    flags_d = flags_q;
    if (take) begin
      flags_d.mbe = mbe_stb;
      flags_d.sbe = ~mbe_stb;
    end else begin
      flags_d.mbe = flags_q.mbe & ~clr.mbe;
      flags_d.sbe = flags_q.sbe & ~clr.sbe;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      syn_q  <= '0;
    end else if (take) begin
      addr_q <= addr_in;
      syn_q  <= syn_in;
    end
  end

  assign flags = flags_q;
endmodule

// File: rtl/ecc_cap_alarm.sv
module ecc_cap_alarm
  import ecc_cap_pkg::*;
(
  input  cap_ctrl_t  ctrl,
  input  cap_flags_t flags,
  output logic       nmi_o,
  output logic       bus_err_o,
  output logic       scrub_en_o
);
  always_comb begin
    nmi_o      = flags.sbe & ctrl.nmi_en;
    bus_err_o  = flags.mbe & ctrl.berr_en;
    scrub_en_o = ~ctrl.scrub_dis;
  end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sbe_stb,
  input  logic              mbe_stb,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              nmi_o,
  output logic              bus_err_o,
  output logic              scrub_en_o
);
  localparam int ADDR_DROP = ADDR_W - ADDR_KEEP;

  logic                 rst_sync_n;
  cap_ctrl_t            ctrl;
  cap_ctrl_t            wr_ctrl;
  cap_flags_t           clr;
  cap_flags_t           flags;
  logic [ADDR_KEEP-1:0] addr_field, addr_q;
  logic [SYN_FIELD-1:0] syn_field, syn_q;
  logic                 unused_wbits;
  logic                 unused_abits;

  assign unused_wbits = ^wdata[ADDR_HI:SYN_LO];

  generate
    if (ADDR_DROP > 0) begin : g_addr_trim
      assign addr_field   = err_addr[ADDR_W-1 -: ADDR_KEEP];
      assign unused_abits = ^err_addr[ADDR_DROP-1:0];
    end else begin : g_addr_pad
      assign addr_field   = {{(ADDR_KEEP-ADDR_W){1'b0}}, err_addr};
      assign unused_abits = 1'b0;
    end
    if (SYN_W >= SYN_FIELD) begin : g_syn_trim
      assign syn_field = err_syn[SYN_FIELD-1:0];
      if (SYN_W > SYN_FIELD) begin : g_syn_drop
        logic unused_sbits;
        assign unused_sbits = ^err_syn[SYN_W-1:SYN_FIELD];
      end
    end else begin : g_syn_pad
      assign syn_field = {{(SYN_FIELD-SYN_W){1'b0}}, err_syn};
    end
  endgenerate

  always_comb begin
    wr_ctrl.scrub_dis = wdata[BIT_SCRUB_DIS];
    wr_ctrl.berr_en   = wdata[BIT_BERR_EN];
    wr_ctrl.nmi_en    = wdata[BIT_NMI_EN];
    clr.mbe           = wr_en & wdata[BIT_MBE];
    clr.sbe           = wr_en & wdata[BIT_SBE];
  end

  ecc_cap_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ecc_cap_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_ctrl (wr_ctrl),
    .ctrl    (ctrl)
  );

  ecc_cap_record u_record (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sbe_stb (sbe_stb),
    .mbe_stb (mbe_stb),
    .addr_in (addr_field),
    .syn_in  (syn_field),
    .clr     (clr),
    .flags   (flags),
    .addr_q  (addr_q),
    .syn_q   (syn_q)
  );

  ecc_cap_alarm u_alarm (
    .ctrl       (ctrl),
    .flags      (flags),
    .nmi_o      (nmi_o),
    .bus_err_o  (bus_err_o),
    .scrub_en_o (scrub_en_o)
  );

  always_comb begin
    rdata                   = '0;
    rdata[BIT_SCRUB_DIS]    = ctrl.scrub_dis;
    rdata[ADDR_HI:ADDR_LO]  = addr_q;
    rdata[SYN_HI:SYN_LO]    = syn_q;
    rdata[BIT_BERR_EN]      = ctrl.berr_en;
    rdata[BIT_NMI_EN]       = ctrl.nmi_en;
    rdata[BIT_MBE]          = flags.mbe;
    rdata[BIT_SBE]          = flags.sbe;
  end
endmodule

// File: rtl/ecc_err_capture_chk.sv
module ecc_err_capture_chk (
  input logic        clk,
  input logic        rst_q_n,
  input logic        sbe_stb,
  input logic        mbe_stb,
  input logic        wr_en,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        nmi_o,
  input logic        bus_err_o,
  input logic        scrub_en_o
);
  logic unused_chk;
  assign unused_chk = ^wdata[30:4];

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(rdata[1] && rdata[0])); // R4

  AST_MBE_PRIORITY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rdata[1:0] == 2'b00 && mbe_stb) |=> rdata[1:0] == 2'b10); // R4

  AST_SBE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rdata[1:0] == 2'b00 && sbe_stb && !mbe_stb) |=> rdata[1:0] == 2'b01); // R2

  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rdata[1:0] != 2'b00) |=> $stable(rdata[30:4])); // R5

  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rdata[1:0] != 2'b00 && !(wr_en && ((wdata[1:0] & rdata[1:0]) != 2'b00)))
      |=> rdata[1:0] == $past(rdata[1:0])); // R5

  AST_W1C_SBE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && wdata[0] && rdata[0]) |=> !rdata[0]); // R6

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_en |=> (rdata[31] == $past(wdata[31]) && rdata[3:2] == $past(wdata[3:2]))); // R7

  AST_SCRUB_LEVEL: assert property (@(posedge clk) disable iff (!rst_q_n)
    scrub_en_o == !rdata[31]); // R8

  AST_NMI_LEVEL: assert property (@(posedge clk) disable iff (!rst_q_n)
    nmi_o == (rdata[0] && rdata[2])); // R9

  AST_BERR_LEVEL: assert property (@(posedge clk) disable iff (!rst_q_n)
    bus_err_o == (rdata[1] && rdata[3])); // R10
endmodule

bind ecc_err_capture ecc_err_capture_chk u_chk (
  .clk        (clk),
  .rst_q_n    (rst_sync_n),
  .sbe_stb    (sbe_stb),
  .mbe_stb    (mbe_stb),
  .wr_en      (wr_en),
  .wdata      (wdata),
  .rdata      (rdata),
  .nmi_o      (nmi_o),
  .bus_err_o  (bus_err_o),
  .scrub_en_o (scrub_en_o)
);

// File: tb/ecc_err_capture_bench.sv
module ecc_err_capture_bench;
  logic        clk;
  logic        rst_n;
  logic        sbe_stb;
  logic        mbe_stb;
  logic [31:0] err_addr;
  logic [7:0]  err_syn;
  logic        wr_en;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        nmi_o;
  logic        bus_err_o;
  logic        scrub_en_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  ecc_err_capture u_ecc_err_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .sbe_stb    (sbe_stb),
    .mbe_stb    (mbe_stb),
    .err_addr   (err_addr),
    .err_syn    (err_syn),
    .wr_en      (wr_en),
    .wdata      (wdata),
    .rdata      (rdata),
    .nmi_o      (nmi_o),
    .bus_err_o  (bus_err_o),
    .scrub_en_o (scrub_en_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] exp_reg(input logic sd, input logic be, input logic ne,
                                          input logic [31:0] a, input logic [7:0] s,
                                          input logic mbe, input logic sbe);
    return {sd, a[31:13], s, be, ne, mbe, sbe};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic m, input logic [31:0] a, input logic [7:0] y,
                     input logic w, input logic [31:0] d);
    @(negedge clk);
    sbe_stb = s; mbe_stb = m; err_addr = a; err_syn = y; wr_en = w; wdata = d;
    @(negedge clk);
    sbe_stb = 0; mbe_stb = 0; wr_en = 0; wdata = '0;
    err_addr = 32'hFFFF_FFFF; err_syn = 8'hFF;
  endtask

  task automatic t_reset();
    chk(rdata === 32'h0, "R1 register after reset", rdata, 32'h0);
    chk({nmi_o, bus_err_o, scrub_en_o} === 3'b001, "R1 outputs after reset",
        {29'h0, nmi_o, bus_err_o, scrub_en_o}, 32'h1);
  endtask

  task automatic t_sbe_then_frozen();
    logic [31:0] e;
    cyc(1, 0, 32'hDEAD_BEEF, 8'h5A, 0, 0);
    e = exp_reg(0, 0, 0, 32'hDEAD_BEEF, 8'h5A, 0, 1);
    chk(rdata === e, "R2 single-bit capture", rdata, e);
    chk(nmi_o === 1'b0, "R9 nmi off while disabled", {31'h0, nmi_o}, 32'h0);
    cyc(1, 0, 32'h0000_1000, 8'h11, 0, 0);
    cyc(0, 1, 32'h8000_0000, 8'h22, 0, 0);
    chk(rdata === e, "R5 later strobes ignored", rdata, e);
    cyc(0, 0, 0, 0, 1, 32'h7FFF_FFF0);
    chk(rdata === e, "R7 read-only fields and R6 zero-write keep record", rdata, e);
    cyc(0, 0, 0, 0, 1, 32'h0000_0004);
    e = exp_reg(0, 0, 1, 32'hDEAD_BEEF, 8'h5A, 0, 1);
    chk(rdata === e, "R7 nmi enable written", rdata, e);
    chk(nmi_o === 1'b1, "R9 nmi with flag and enable", {31'h0, nmi_o}, 32'h1);
    cyc(0, 0, 0, 0, 1, 32'h0000_0005);
    chk(rdata[1:0] === 2'b00, "R6 single-bit flag cleared", rdata, {rdata[31:2], 2'b00});
    chk(nmi_o === 1'b0, "R9 nmi drops with flag", {31'h0, nmi_o}, 32'h0);
  endtask

  task automatic t_mbe();
    logic [31:0] e;
    cyc(0, 1, 32'h1234_5000, 8'hC3, 0, 0);
    e = exp_reg(0, 0, 1, 32'h1234_5000, 8'hC3, 1, 0);
    chk(rdata === e, "R3 multi-bit capture", rdata, e);
    chk({nmi_o, bus_err_o} === 2'b00, "R10 bus error off while disabled",
        {30'h0, nmi_o, bus_err_o}, 32'h0);
    cyc(0, 0, 0, 0, 1, 32'h0000_0008);
    chk(bus_err_o === 1'b1, "R10 bus error with flag and enable", {31'h0, bus_err_o}, 32'h1);
    cyc(0, 0, 0, 0, 1, 32'h0000_0009);
    chk(rdata[1:0] === 2'b10, "R6 clearing other flag leaves multi-bit", rdata, {rdata[31:2], 2'b10});
    cyc(0, 0, 0, 0, 1, 32'h0000_000A);
    chk(rdata[1:0] === 2'b00 && bus_err_o === 1'b0, "R6 multi-bit flag cleared",
        {rdata[31:2], rdata[1:0]}, {rdata[31:2], 2'b00});
  endtask

  task automatic t_both();
    logic [31:0] e;
    cyc(1, 1, 32'hA5A5_A5A5, 8'h3C, 0, 0);
    e = exp_reg(0, 1, 0, 32'hA5A5_A5A5, 8'h3C, 1, 0);
    chk(rdata === e, "R4 simultaneous strobes record multi-bit only", rdata, e);
    cyc(0, 0, 0, 0, 1, 32'h0000_0002);
    chk(rdata[1:0] === 2'b00, "R6 re-armed after clear", rdata, {rdata[31:2], 2'b00});
  endtask

  task automatic t_scrub();
    cyc(0, 0, 0, 0, 1, 32'h8000_0000);
    chk(scrub_en_o === 1'b0 && rdata[31] === 1'b1, "R8 scrub disabled",
        {rdata[31], 30'h0, scrub_en_o}, {1'b1, 31'h0});
    cyc(0, 0, 0, 0, 1, 32'h0000_0000);
    chk(scrub_en_o === 1'b1 && rdata[31] === 1'b0, "R8 scrub enabled",
        {rdata[31], 30'h0, scrub_en_o}, 32'h1);
  endtask

  task automatic t_coincide();
    logic [31:0] e;
    cyc(1, 0, 32'h0BAD_F00D, 8'h99, 1, 32'h0000_0001);
    e = exp_reg(0, 0, 0, 32'h0BAD_F00D, 8'h99, 0, 1);
    chk(rdata === e, "R11 strobe with write while clear is captured", rdata, e);
    cyc(0, 1, 32'h7777_0000, 8'h44, 1, 32'h0000_0001);
    e = exp_reg(0, 0, 0, 32'h0BAD_F00D, 8'h99, 0, 0);
    chk(rdata === e, "R11 strobe with clearing write is dropped", rdata, e);
    cyc(0, 1, 32'h7777_0000, 8'h44, 0, 0);
    e = exp_reg(0, 0, 0, 32'h7777_0000, 8'h44, 1, 0);
    chk(rdata === e, "R6 next error captured after clear", rdata, e);
  endtask

  initial begin
    rst_n = 0; sbe_stb = 0; mbe_stb = 0; wr_en = 0; wdata = '0;
    err_addr = '0; err_syn = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sbe_then_frozen();
    t_mbe();
    t_both();
    t_scrub();
    t_coincide();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule